// File: doc/BRIEF.md
# Frame-Synchronous Time-Slot Switch with Sub-Slot Transfer

The block moves 8-bit time-slot data between a line-side port and a trunk-side port, each carrying 128 slots per frame in each direction. Receive data from both ports arrives one slot per clock on parallel buses, tagged by a frame-start pulse. It is stored in a two-bank data memory. Each bank holds one full frame for both ports. While one bank fills with the current frame, the other bank is read to build the transmit slots of the current frame. The transmit slots therefore always carry data from the frame before.

A host programs a control table with one entry per destination slot. The trunk side has four lane entries per slot. Each entry holds a valid flag, the source port, a 7-bit source slot, a width code and a position. A connection can move a whole byte, a 4-bit sub-slot or a 2-bit sub-slot. On the trunk side, the position is taken from the entry, and up to four lanes can be merged into one outgoing byte. On the line side, the position of a sub-slot is fixed for the port by parameters. Loopback connections (line to line, trunk to trunk) use the same entries. Once an entry is written, the transfer repeats every frame with no further host action.

Top module: `tsi_switch`

## Requirements
- R1: After reset, `tx_vld_o` is 0, both transmit buses read 8'hFF, `cfg_rdata` is 0, and every control entry reads back as 0 (invalid).
- R2: Control entry format is {valid[12], src_is_trunk[11], src_slot[10:4], width[3:2], pos[1:0]}. `cfg_addr[9]`=0 selects line destination slot `cfg_addr[6:0]`. `cfg_addr[9]`=1 selects trunk lane `cfg_addr[8:7]` of slot `cfg_addr[6:0]`. A write with `cfg_we` takes effect at the clock edge. `cfg_rdata` returns the entry at `cfg_addr` one clock later.
- R3: A cycle with `frame_i`=1 carries slot 0. Each later clock carries the next slot up to 127, and then the slot run stops until the next `frame_i`. The transmit bytes of slot s appear one clock after the cycle of slot s, with `tx_vld_o`=1 and `tx_slot_o`=s. At all other times `tx_vld_o`=0 and both buses read 8'hFF.
- R4: Transmit data in a frame comes from receive data of the previous frame, for any source slot, including source slots later than the destination slot. During the first frame after reset, every transmit byte is 8'hFF.
- R5: A valid entry with width code 0 copies the whole source byte, line to trunk or trunk to line.
- R6: Loopback entries (line to line, trunk to trunk) switch data like cross-port entries.
- R7: Width code 1 moves 4 bits. Position 0 is bits [7:4] and position 1 is bits [3:0]. On the trunk side, bit 0 of the entry's position field selects the position.
- R8: Width code 2 moves 2 bits. Position p is bits [7-2p:6-2p]. On the trunk side, the entry's position field selects the position.
- R9: A trunk destination slot merges up to four lanes of any mixture of widths. Where lanes overlap, the lane with the higher index wins.
- R10: On the line side, sub-slot positions are fixed by the parameters `LINE_POS4` and `LINE_POS2` (defaults 0 and 1, that is bits [7:4] and bits [5:4]). The position field of the entry has no effect on the line side.
- R11: Destination bits not covered by a valid entry read 1. An entry with the valid bit cleared leaves its destination slot all ones.
- R12: Programmed connections repeat in every following frame with no host writes. A rewritten entry takes effect at the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control entry write strobe |
| cfg_addr | input | 10 | Control entry address |
| cfg_wdata | input | 13 | Control entry write data |
| cfg_rdata | output | 13 | Control entry read data, one clock after address |
| frame_i | input | 1 | Frame start, marks slot 0 |
| line_rx_i | input | 8 | Line-side receive byte of the current slot |
| trunk_rx_i | input | 8 | Trunk-side receive byte of the current slot |
| tx_vld_o | output | 1 | Transmit bytes valid |
| tx_slot_o | output | 7 | Slot number of the transmit bytes |
| line_tx_o | output | 8 | Line-side transmit byte |
| trunk_tx_o | output | 8 | Trunk-side transmit byte |

## Verification
Readback of a control entry is due one clock after its address is presented. A transmit byte is due one clock after its slot's receive cycle, and its data is the frame sent one frame earlier. The bench drives inputs and samples on falling edges. It files each transmit byte under the `tx_slot_o` tag that comes with it. It compares whole frames only after the run of 128 slots and three idle cycles have passed. The expected bytes come from a shadow copy of the control entries and of the previous frame's receive data.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int unsigned SLOT_W = 7;
  localparam int unsigned NSLOT  = 1 << SLOT_W;
  localparam int unsigned NLANE  = 4;
  localparam int unsigned LANE_W = $clog2(NLANE);
  localparam int unsigned CFG_AW = 1 + LANE_W + SLOT_W;

  typedef enum logic [1:0] {W_BYTE = 2'd0, W_NIB = 2'd1, W_DIB = 2'd2, W_RSV = 2'd3} wcode_e;

  typedef struct packed {
    logic              vld;
    logic              src_trk;
    logic [SLOT_W-1:0] src;
    wcode_e            wid;
    logic [1:0]        pos;
  } ent_t;

  localparam int unsigned ENT_W = $bits(ent_t);

  // number of bits moved for a width code (reserved code moves a full byte)
  function automatic int unsigned sub_width(wcode_e c);
    case (c)
      W_NIB:   return 4;
      W_DIB:   return 2;
      default: return 8;
    endcase
  endfunction

  // lowest bit index of the sub-slot selected by width code and position
  function automatic int unsigned sub_lsb(wcode_e c, logic [1:0] p);
    case (c)
      W_NIB:   return p[0] ? 0 : 4;
      W_DIB:   return 6 - 2 * int'(p);
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] span_mask(int unsigned w, int unsigned lsb);
    logic [7:0] m;
    m = '0;
    for (int unsigned i = 0; i < 8; i++)
      if (i < w) m[3'(lsb + i)] = 1'b1;
    return m;
  endfunction

  // copy w bits from src starting at sl into a zero byte starting at dl
  function automatic logic [7:0] place_bits(logic [7:0] src, int unsigned w,
                                            int unsigned sl, int unsigned dl);
    logic [7:0] r;
    r = '0;
    for (int unsigned i = 0; i < 8; i++)
      if (i < w) r[3'(dl + i)] = src[3'(sl + i)];
    return r;
  endfunction
endpackage

// File: rtl/tsi_slot_timer.sv
module tsi_slot_timer
  import tsi_pkg::*;
#(
  parameter int unsigned NS = NSLOT,
  localparam int unsigned SW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_i,
  output logic          cur_act,
  output logic [SW-1:0] cur_slot,
  output logic          cur_bank
);
  localparam logic [SW-1:0] LAST = SW'(NS - 1);

  logic          run_q;
  logic [SW-1:0] slot_q;
  logic          bank_q;

  assign cur_act  = frame_i | (run_q & (slot_q != LAST));
  assign cur_slot = frame_i ? '0 : slot_q + 1'b1;
  assign cur_bank = frame_i ? ~bank_q : bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      slot_q <= '0;
      bank_q <= 1'b0;
    end else begin
      run_q  <= cur_act;
      bank_q <= cur_bank;
      if (cur_act) slot_q <= cur_slot;
    end
  end

  // R4: banks swap exactly at a frame start
  a_r4_bank_swap: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i |=> (bank_q != $past(bank_q)));
  a_r4_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_i |=> $stable(bank_q));
  // R3: frame start restarts at slot 0; run ends after the last slot
  a_r3_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i |=> (run_q && slot_q == '0));
  a_r3_run_end: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && slot_q == LAST && !frame_i) |=> !run_q);
endmodule

// File: rtl/tsi_ctrl_mem.sv
module tsi_ctrl_mem
  import tsi_pkg::*;
#(
  parameter int unsigned NS = NSLOT,
  parameter int unsigned NL = NLANE,
  localparam int unsigned SW = $clog2(NS),
  localparam int unsigned LW = $clog2(NL),
  localparam int unsigned AW = 1 + LW + SW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [ENT_W-1:0]     cfg_wdata,
  output logic [ENT_W-1:0]     cfg_rdata,
  input  logic [SW-1:0]        rd_slot,
  output ent_t                 line_ent,
  output ent_t [NL-1:0]        trk_ent
);
  ent_t line_tab [NS];
  ent_t trk_tab  [NL][NS];

  logic          a_trk;
  logic [LW-1:0] a_lane;
  logic [SW-1:0] a_slot;

  assign a_trk  = cfg_addr[AW-1];
  assign a_lane = cfg_addr[SW +: LW];
  assign a_slot = cfg_addr[SW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) begin
        line_tab[s] <= '0;
        for (int l = 0; l < NL; l++) trk_tab[l][s] <= '0;
      end
      cfg_rdata <= '0;
    end else begin
      if (cfg_we) begin
        if (a_trk) trk_tab[a_lane][a_slot] <= ent_t'(cfg_wdata);
        else       line_tab[a_slot]        <= ent_t'(cfg_wdata);
      end
      cfg_rdata <= a_trk ? trk_tab[a_lane][a_slot] : line_tab[a_slot];
    end
  end

  assign line_ent = line_tab[rd_slot];
  for (genvar l = 0; l < NL; l++) begin : g_lane
    assign trk_ent[l] = trk_tab[l][rd_slot];
  end
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
  import tsi_pkg::*;
#(
  parameter int unsigned NS  = NSLOT,
  parameter int unsigned NRD = 1 + NLANE,
  localparam int unsigned SW = $clog2(NS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic                     wbank,
  input  logic [SW-1:0]            wslot,
  input  logic [7:0]               line_wd,
  input  logic [7:0]               trk_wd,
  input  logic                     rbank,
  input  logic [NRD-1:0]           rd_trk,
  input  logic [NRD-1:0][SW-1:0]   rd_slot,
  output logic [NRD-1:0][7:0]      rd_data
);
  // mem[bank][port][slot], port 0 = line, 1 = trunk
  logic [7:0] mem [2][2][NS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int p = 0; p < 2; p++)
          for (int s = 0; s < NS; s++) mem[b][p][s] <= 8'hFF;
    end else if (we) begin
      mem[wbank][0][wslot] <= line_wd;
      mem[wbank][1][wslot] <= trk_wd;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data[r] = mem[rbank][rd_trk[r]][rd_slot[r]];
  end

  // R4: the bank being read is never the bank being filled
  a_r4_bank_split: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (rbank != wbank));
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int unsigned LINE_POS4 = 0,
  parameter int unsigned LINE_POS2 = 1,
  localparam int unsigned NRD = 1 + NLANE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ENT_W-1:0]  cfg_wdata,
  output logic [ENT_W-1:0]  cfg_rdata,
  input  logic              frame_i,
  input  logic [7:0]        line_rx_i,
  input  logic [7:0]        trunk_rx_i,
  output logic              tx_vld_o,
  output logic [SLOT_W-1:0] tx_slot_o,
  output logic [7:0]        line_tx_o,
  output logic [7:0]        trunk_tx_o
);
  function automatic logic [1:0] line_pos(wcode_e c);
    return (c == W_NIB) ? 2'(LINE_POS4) : 2'(LINE_POS2);
  endfunction

  logic              cur_act;
  logic [SLOT_W-1:0] cur_slot;
  logic              cur_bank;

  tsi_slot_timer #(.NS(NSLOT)) u_timer (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i),
    .cur_act(cur_act), .cur_slot(cur_slot), .cur_bank(cur_bank)
  );

  ent_t              line_ent;
  ent_t [NLANE-1:0]  trk_ent;
  ent_t [NRD-1:0]    all_ent;

  tsi_ctrl_mem #(.NS(NSLOT), .NL(NLANE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rd_slot(cur_slot),
    .line_ent(line_ent), .trk_ent(trk_ent)
  );

  assign all_ent = {trk_ent, line_ent};

  logic [NRD-1:0]             rd_trk;
  logic [NRD-1:0][SLOT_W-1:0] rd_slot;
  logic [NRD-1:0][7:0]        rd_data;

  for (genvar p = 0; p < NRD; p++) begin : g_src
    assign rd_trk[p]  = all_ent[p].src_trk;
    assign rd_slot[p] = all_ent[p].src;
  end

  tsi_data_mem #(.NS(NSLOT), .NRD(NRD)) u_data (
    .clk(clk), .rst_n(rst_n), .we(cur_act), .wbank(cur_bank), .wslot(cur_slot),
    .line_wd(line_rx_i), .trk_wd(trunk_rx_i), .rbank(~cur_bank),
    .rd_trk(rd_trk), .rd_slot(rd_slot), .rd_data(rd_data)
  );

  // per-lane extraction: port 0 targets the line side, ports 1.. the trunk lanes
  logic [NRD-1:0][7:0] fld;
  logic [NRD-1:0][7:0] msk;
  logic [7:0]          line_nx, trk_nx, trk_cov;

  always_comb begin
    for (int p = 0; p < NRD; p++) begin
      int unsigned w, sl, dl;
      w  = sub_width(all_ent[p].wid);
      sl = all_ent[p].src_trk ? sub_lsb(all_ent[p].wid, all_ent[p].pos)
                              : sub_lsb(all_ent[p].wid, line_pos(all_ent[p].wid));
      dl = (p == 0) ? sub_lsb(all_ent[p].wid, line_pos(all_ent[p].wid))
                    : sub_lsb(all_ent[p].wid, all_ent[p].pos);
      fld[p] = place_bits(rd_data[p], w, sl, dl);
      msk[p] = all_ent[p].vld ? span_mask(w, dl) : 8'h00;
    end
  end

  // merge: idle ones, later lanes override earlier ones
  always_comb begin
    line_nx = (8'hFF & ~msk[0]) | (fld[0] & msk[0]);
    trk_nx  = 8'hFF;
    trk_cov = 8'h00;
    for (int k = 1; k < NRD; k++) begin
      trk_nx  = (trk_nx & ~msk[k]) | (fld[k] & msk[k]);
      trk_cov = trk_cov | msk[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_vld_o   <= 1'b0;
      tx_slot_o  <= '0;
      line_tx_o  <= 8'hFF;
      trunk_tx_o <= 8'hFF;
    end else begin
      tx_vld_o   <= cur_act;
      tx_slot_o  <= cur_slot;
      line_tx_o  <= cur_act ? line_nx : 8'hFF;
      trunk_tx_o <= cur_act ? trk_nx  : 8'hFF;
    end
  end

  // R11: invalid line entry yields an idle slot
  a_r11_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_act && !line_ent.vld) |=> (line_tx_o == 8'hFF));
  // R11: trunk bits outside every valid lane read one
  a_r11_trunk_uncov: assert property (@(posedge clk) disable iff (!rst_n)
    cur_act |=> ((trunk_tx_o | $past(trk_cov)) == 8'hFF));
  // R3: outside a slot run the transmit side is idle
  a_r3_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_act |=> (!tx_vld_o && line_tx_o == 8'hFF && trunk_tx_o == 8'hFF));
  // R5: a full-byte line connection copies the stored source byte
  a_r5_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_act && line_ent.vld && line_ent.wid == W_BYTE) |=> (line_tx_o == $past(rd_data[0])));
endmodule

// File: tb/tsi_switch_tb.sv
module tsi_switch_tb;
  localparam int NS = 128;
  localparam int LP4 = 0;
  localparam int LP2 = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [9:0]  cfg_addr = '0;
  logic [12:0] cfg_wdata = '0;
  logic [12:0] cfg_rdata;
  logic        frame_i = 1'b0;
  logic [7:0]  line_rx_i = '0, trunk_rx_i = '0;
  logic        tx_vld_o;
  logic [6:0]  tx_slot_o;
  logic [7:0]  line_tx_o, trunk_tx_o;

  always #2.5 clk = ~clk;

  tsi_switch u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .frame_i(frame_i),
    .line_rx_i(line_rx_i), .trunk_rx_i(trunk_rx_i), .tx_vld_o(tx_vld_o),
    .tx_slot_o(tx_slot_o), .line_tx_o(line_tx_o), .trunk_tx_o(trunk_tx_o)
  );

  int n_chk = 0, n_err = 0;
  logic [12:0] sh_l [NS];
  logic [12:0] sh_t [4][NS];
  logic [7:0]  pv_l [NS];
  logic [7:0]  pv_t [NS];
  logic [7:0]  cap_l [NS];
  logic [7:0]  cap_t [NS];
  int cnt = 0, seq_err = 0, exp_next = 0;

  always @(negedge clk) begin
    if (tx_vld_o) begin
      if (int'(tx_slot_o) != exp_next) seq_err++;
      cap_l[tx_slot_o] = line_tx_o;
      cap_t[tx_slot_o] = trunk_tx_o;
      exp_next++;
      cnt++;
    end
  end

  task automatic chk(input string tag, input logic [12:0] act, input logic [12:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] gl(int seed, int s);
    return 8'(s * 3 + seed * 17) ^ 8'hA5;
  endfunction
  function automatic logic [7:0] gt(int seed, int s);
    return 8'(s * 7 + seed * 29) ^ 8'h3C;
  endfunction

  function automatic logic [12:0] mk(bit v, bit trk, int src, int wid, int pos);
    return {v, trk, 7'(src), 2'(wid), 2'(pos)};
  endfunction

  function automatic int lsb_of(int w, int pos);
    if (w == 4) return (pos % 2 == 1) ? 0 : 4;
    if (w == 2) return 6 - 2 * pos;
    return 0;
  endfunction

  // reference byte for a destination slot from shadow table and previous frame
  function automatic logic [7:0] model(bit to_trk, int s);
    logic [7:0]  r, sb;
    logic [12:0] e;
    int w, sl, dl, lp;
    r = 8'hFF;
    for (int k = 0; k < (to_trk ? 4 : 1); k++) begin
      e = to_trk ? sh_t[k][s] : sh_l[s];
      if (e[12]) begin
        w  = (e[3:2] == 2'd1) ? 4 : (e[3:2] == 2'd2) ? 2 : 8;
        lp = (w == 4) ? LP4 : LP2;
        sb = e[11] ? pv_t[e[10:4]] : pv_l[e[10:4]];
        sl = e[11] ? lsb_of(w, int'(e[1:0])) : lsb_of(w, lp);
        dl = to_trk ? lsb_of(w, int'(e[1:0])) : lsb_of(w, lp);
        for (int b = 0; b < w; b++) r[dl + b] = sb[sl + b];
      end
    end
    return r;
  endfunction

  task automatic wr_line(input int slot, input logic [12:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {1'b0, 2'b00, 7'(slot)}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    sh_l[slot] = d;
  endtask

  task automatic wr_trk(input int lane, input int slot, input logic [12:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {1'b1, 2'(lane), 7'(slot)}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    sh_t[lane][slot] = d;
  endtask

  task automatic rd_ent(input logic [9:0] a, output logic [12:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic run_frame(input int seed);
    cnt = 0; seq_err = 0; exp_next = 0;
    for (int s = 0; s < NS; s++) begin
      @(negedge clk);
      frame_i = (s == 0);
      line_rx_i = gl(seed, s);
      trunk_rx_i = gt(seed, s);
    end
    @(negedge clk);
    frame_i = 1'b0; line_rx_i = '0; trunk_rx_i = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_prev(input int seed);
    for (int s = 0; s < NS; s++) begin
      pv_l[s] = gl(seed, s);
      pv_t[s] = gt(seed, s);
    end
  endtask

  task automatic t_reset;
    logic [12:0] d;
    @(negedge clk);
    chk("R1 tx_vld", 13'(tx_vld_o), 13'd0);
    chk("R1 line_tx", 13'(line_tx_o), 13'hFF);
    chk("R1 trunk_tx", 13'(trunk_tx_o), 13'hFF);
    chk("R1 cfg_rdata", cfg_rdata, 13'd0);
    rd_ent({1'b1, 2'd3, 7'd127}, d);
    chk("R1 trunk entry cleared", d, 13'd0);
    rd_ent({1'b0, 2'd0, 7'd5}, d);
    chk("R1 line entry cleared", d, 13'd0);
  endtask

  task automatic t_program;
    logic [12:0] d;
    wr_line(0,  mk(1, 1, 127, 0, 0)); // R4 later source slot
    wr_line(10, mk(1, 1, 20, 0, 0));  // R5 trunk->line byte
    wr_line(11, mk(1, 0, 3, 0, 0));   // R6 line loop
    wr_line(12, mk(1, 1, 100, 1, 1)); // R7 R10 nibble
    wr_line(13, mk(1, 1, 5, 2, 2));   // R8 R10 dibit
    wr_line(14, mk(1, 0, 127, 2, 3)); // R10 both sides fixed
    wr_line(15, mk(0, 1, 6, 0, 0));   // R11 invalid
    wr_trk(0, 30, mk(1, 0, 40, 0, 0)); // R5 line->trunk
    wr_trk(0, 31, mk(1, 1, 2, 0, 0));  // R6 trunk loop
    wr_trk(0, 32, mk(1, 0, 1, 2, 0));  // R9 lanes
    wr_trk(1, 32, mk(1, 1, 9, 2, 1));
    wr_trk(2, 32, mk(1, 0, 2, 1, 1));
    wr_trk(3, 32, mk(1, 1, 70, 2, 3)); // overlaps lane 2
    wr_trk(0, 33, mk(1, 1, 50, 1, 0)); // R7 R11
    wr_trk(2, 34, mk(1, 0, 60, 2, 2)); // R8 R11
    rd_ent({1'b0, 2'd0, 7'd13}, d);
    chk("R2 line readback", d, mk(1, 1, 5, 2, 2));
    rd_ent({1'b1, 2'd3, 7'd32}, d);
    chk("R2 trunk lane readback", d, mk(1, 1, 70, 2, 3));
    rd_ent({1'b0, 2'd0, 7'd15}, d);
    chk("R2 invalid entry readback", d, mk(0, 1, 6, 0, 0));
  endtask

  task automatic t_first_frame;
    int bad = 0;
    run_frame(1);
    chk("R3 slot count", 13'(cnt), 13'(NS));
    chk("R3 slot order", 13'(seq_err), 13'd0);
    chk("R3 idle after run", 13'(tx_vld_o), 13'd0);
    for (int s = 0; s < NS; s++) if (cap_l[s] != 8'hFF || cap_t[s] != 8'hFF) bad++;
    chk("R4 first frame all ones", 13'(bad), 13'd0);
    set_prev(1);
  endtask

  task automatic t_switch_frame;
    int bad = 0;
    run_frame(2);
    chk("R4 later source slot", 13'(cap_l[0]), 13'(gt(1, 127)));
    chk("R5 trunk to line byte", 13'(cap_l[10]), 13'(model(0, 10)));
    chk("R5 line to trunk byte", 13'(cap_t[30]), 13'(model(1, 30)));
    chk("R6 line loopback", 13'(cap_l[11]), 13'(gl(1, 3)));
    chk("R6 trunk loopback", 13'(cap_t[31]), 13'(gt(1, 2)));
    chk("R7 R10 nibble to line", 13'(cap_l[12]), 13'(model(0, 12)));
    chk("R8 R10 dibit to line", 13'(cap_l[13]), 13'(model(0, 13)));
    chk("R10 line to line dibit", 13'(cap_l[14]), 13'(model(0, 14)));
    chk("R11 invalid line entry", 13'(cap_l[15]), 13'hFF);
    chk("R9 four lane merge", 13'(cap_t[32]), 13'(model(1, 32)));
    chk("R7 R11 trunk nibble", 13'(cap_t[33]), 13'(model(1, 33)));
    chk("R8 R11 trunk dibit", 13'(cap_t[34]), 13'(model(1, 34)));
    for (int s = 0; s < NS; s++)
      if (cap_l[s] != model(0, s) || cap_t[s] != model(1, s)) bad++;
    chk("R11 whole frame vs model", 13'(bad), 13'd0);
    set_prev(2);
  endtask

  task automatic t_persist;
    int bad = 0;
    run_frame(3);
    for (int s = 0; s < NS; s++)
      if (cap_l[s] != model(0, s) || cap_t[s] != model(1, s)) bad++;
    chk("R12 repeat without writes", 13'(bad), 13'd0);
    chk("R12 trunk loop new data", 13'(cap_t[31]), 13'(gt(2, 2)));
    set_prev(3);
    wr_line(10, mk(0, 1, 20, 0, 0));
    wr_trk(0, 30, mk(1, 0, 41, 0, 0));
    run_frame(4);
    chk("R12 R11 disabled entry idle", 13'(cap_l[10]), 13'hFF);
    chk("R12 rewritten source", 13'(cap_t[30]), 13'(gl(3, 41)));
    chk("R12 other slot kept", 13'(cap_l[11]), 13'(gl(3, 3)));
  endtask

  bit done = 1'b0;

  initial begin
    for (int s = 0; s < NS; s++) begin
      sh_l[s] = '0;
      for (int k = 0; k < 4; k++) sh_t[k][s] = '0;
      pv_l[s] = 8'hFF; pv_t[s] = 8'hFF;
      cap_l[s] = '0; cap_t[s] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_program();
    t_first_frame();
    t_switch_frame();
    t_persist();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule